// File: doc/BRIEF.md
# Timer Channel Status Flag Register

This block holds the 8-bit status byte of one channel of an up/down timer. It watches the counter's present and next values, the count direction and the two general registers of the channel. From these it keeps four sticky event flags: counter wrap upward, counter wrap downward, and a compare-or-capture event for each of general registers A and B. The same byte also shows the live count direction as a read-only bit.

Software clears a flag with a two-step handshake. A bus read must first return the flag as 1, and a later write of 0 to that bit then clears it. A write of 0 with no such read leaves the flag alone, so a flag that was never seen cannot be lost. Transfer engines can also clear flags when they are launched by a flag's interrupt. Flag A has two such acknowledge paths and flag B has one. Each flag drives an interrupt request, gated by its own enable input.

Top module: `tmr_stat_reg`

## Requirements
- R1: After reset a read returns 0xC0. Bits 7 and 6 always read 1, bit 2 always reads 0, and the flags sit at bit 0 (A), bit 1 (B), bit 3 (up-wrap) and bit 4 (down-wrap).
- R2: Bit 5 of a read returns the level of `dir_up` in the read cycle: 1 while counting up, 0 while counting down.
- R3: When `dir_up` is 1, `cnt_cur` is all ones and `cnt_nxt` is zero, the up-wrap flag (bit 3) is 1 from the following cycle.
- R4: When `dir_up` is 0, `cnt_cur` is zero and `cnt_nxt` is all ones, the down-wrap flag (bit 4) is 1 from the following cycle.
- R5: With its mode select at 0 (compare), a general register's flag sets when `cnt_nxt` equals that register and differs from `cnt_cur`. With its mode select at 1 (capture), the flag sets on the register's capture strobe. Each mode ignores the other mode's trigger.
- R6: A write with a bit at 0 clears that flag only if a read since the previous write returned the flag as 1. Any write uses up that permission. Writing 1 never clears a flag.
- R7: Flag A clears when `xc_go_a` is 1 with `xc_hold_a` at 0, or when `dm_go_a` is 1 with `dm_clr_en_a` at 1.
- R8: Flag B clears only when `xc_go_b` is 1 with `xc_hold_b` at 0. The A acknowledges leave it alone.
- R9: When a set event and any clear fall in the same cycle, the flag ends up set.
- R10: Each interrupt output is 1 exactly while its flag and its enable input are both 1.
- R11: Writes to bits 7, 6, 5 and 2 have no effect on what is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_cur | input | CNT_W | Present counter value |
| cnt_nxt | input | CNT_W | Counter value after this clock |
| dir_up | input | 1 | 1 = counting up, 0 = counting down |
| gra | input | CNT_W | General register A value |
| grb | input | CNT_W | General register B value |
| mode_cap_a | input | 1 | Register A: 1 capture, 0 compare |
| mode_cap_b | input | 1 | Register B: 1 capture, 0 compare |
| cap_a | input | 1 | Capture strobe loading register A |
| cap_b | input | 1 | Capture strobe loading register B |
| xc_go_a | input | 1 | Transfer controller launched by A interrupt |
| xc_hold_a | input | 1 | Its disable-clear control for A |
| dm_go_a | input | 1 | DMA engine launched by A interrupt |
| dm_clr_en_a | input | 1 | Its acknowledge-clear enable |
| xc_go_b | input | 1 | Transfer controller launched by B interrupt |
| xc_hold_b | input | 1 | Its disable-clear control for B |
| rd_en | input | 1 | Status read strobe |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| ien_a | input | 1 | Interrupt enable, flag A |
| ien_b | input | 1 | Interrupt enable, flag B |
| ien_ovf | input | 1 | Interrupt enable, up-wrap |
| ien_unf | input | 1 | Interrupt enable, down-wrap |
| irq_a | output | 1 | Interrupt request, flag A |
| irq_b | output | 1 | Interrupt request, flag B |
| irq_ovf | output | 1 | Interrupt request, up-wrap |
| irq_unf | output | 1 | Interrupt request, down-wrap |

## Verification
The bench builds the block with CNT_W = 4, so the counter has only sixteen values. This lets it step every present value in both directions and compute arithmetically which steps must raise a wrap flag. It also places each general register at each of the sixteen values, checking a hit when the counter steps onto it and no hit when the counter steps past it or stands on it. The same narrow width keeps the handshake, acknowledge and same-cycle set-versus-clear sequences short, so each ordering can be driven on its own.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
  localparam int NFLAG   = 4;
  // internal flag index
  localparam int IX_A    = 0;
  localparam int IX_B    = 1;
  localparam int IX_OVF  = 2;
  localparam int IX_UNF  = 3;
  // bit positions in the status byte
  localparam int POS_A   = 0;
  localparam int POS_B   = 1;
  localparam int POS_OVF = 3;
  localparam int POS_UNF = 4;
  localparam int POS_DIR = 5;
  localparam logic [7:0] RSV_ONES = 8'hC0;

  function automatic int flag_pos(input int ix);
    case (ix)
      IX_A:    return POS_A;
      IX_B:    return POS_B;
      IX_OVF:  return POS_OVF;
      default: return POS_UNF;
    endcase
  endfunction
endpackage

// File: rtl/tmr_evt_det.sv
module tmr_evt_det #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]      cnt_cur,
  input  logic [CNT_W-1:0]      cnt_nxt,
  input  logic                  dir_up,
  input  logic [1:0][CNT_W-1:0] gr_val,
  input  logic [1:0]            cap,
  input  logic [1:0]            mode_cap,
  output logic [3:0]            ev
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] BOT = '0;

  logic moved;
  assign moved = (cnt_nxt != cnt_cur);

  for (genvar g = 0; g < 2; g++) begin : g_gr
    logic hit;
    assign hit   = moved && (cnt_nxt == gr_val[g]);
    assign ev[g] = mode_cap[g] ? cap[g] : hit;
  end

  assign ev[2] =  dir_up && (cnt_cur == TOP) && (cnt_nxt == BOT);
  assign ev[3] = !dir_up && (cnt_cur == BOT) && (cnt_nxt == TOP);
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic hw_clr,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag,
  output logic arm
);
  logic sw_clr;
  logic flag_d;
  logic arm_d;

  assign sw_clr = wr_en && !wr_bit && arm;
  assign flag_d = set_ev || (flag && !(hw_clr || sw_clr));

  always_comb begin
    if (rd_en)      arm_d = flag;
    else if (wr_en) arm_d = 1'b0;
    else            arm_d = arm && flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      arm  <= 1'b0;
    end else begin
      flag <= flag_d;
      arm  <= arm_d;
    end
  end
endmodule

// File: rtl/tmr_stat_reg.sv
module tmr_stat_reg
  import tmr_stat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_cur,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             dir_up,
  input  logic [CNT_W-1:0] gra,
  input  logic [CNT_W-1:0] grb,
  input  logic             mode_cap_a,
  input  logic             mode_cap_b,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic             xc_go_a,
  input  logic             xc_hold_a,
  input  logic             dm_go_a,
  input  logic             dm_clr_en_a,
  input  logic             xc_go_b,
  input  logic             xc_hold_b,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             ien_a,
  input  logic             ien_b,
  input  logic             ien_ovf,
  input  logic             ien_unf,
  output logic             irq_a,
  output logic             irq_b,
  output logic             irq_ovf,
  output logic             irq_unf
);
  logic [NFLAG-1:0] ev;
  logic [NFLAG-1:0] hw_clr;
  logic [NFLAG-1:0] flag;
  logic [NFLAG-1:0] arm;
  logic [7:0]       rd_img;
  logic             unused_wr;

  assign unused_wr = ^{wr_data[7:5], wr_data[2]};

  tmr_evt_det #(.CNT_W(CNT_W)) u_det (
    .cnt_cur  (cnt_cur),
    .cnt_nxt  (cnt_nxt),
    .dir_up   (dir_up),
    .gr_val   ({grb, gra}),
    .cap      ({cap_b, cap_a}),
    .mode_cap ({mode_cap_b, mode_cap_a}),
    .ev       (ev)
  );

  assign hw_clr[IX_A]   = (xc_go_a && !xc_hold_a) || (dm_go_a && dm_clr_en_a);
  assign hw_clr[IX_B]   = xc_go_b && !xc_hold_b;
  assign hw_clr[IX_OVF] = 1'b0;
  assign hw_clr[IX_UNF] = 1'b0;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam int POS = flag_pos(i);
    tmr_flag_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_ev (ev[i]),
      .hw_clr (hw_clr[i]),
      .rd_en  (rd_en),
      .wr_en  (wr_en),
      .wr_bit (wr_data[POS]),
      .flag   (flag[i]),
      .arm    (arm[i])
    );
  end

  always_comb begin
    rd_img          = RSV_ONES;
    rd_img[POS_DIR] = dir_up;
    rd_img[POS_A]   = flag[IX_A];
    rd_img[POS_B]   = flag[IX_B];
    rd_img[POS_OVF] = flag[IX_OVF];
    rd_img[POS_UNF] = flag[IX_UNF];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= RSV_ONES;
    else if (rd_en) rd_data <= rd_img;
  end

  assign irq_a   = flag[IX_A]   && ien_a;
  assign irq_b   = flag[IX_B]   && ien_b;
  assign irq_ovf = flag[IX_OVF] && ien_ovf;
  assign irq_unf = flag[IX_UNF] && ien_unf;
endmodule

// File: rtl/tmr_stat_chk.sv
module tmr_stat_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt_cur,
  input logic [CNT_W-1:0] cnt_nxt,
  input logic             dir_up,
  input logic             wr_en,
  input logic             wr_ovf_bit,
  input logic [2:0]       rd_rsv,
  input logic             xc_go_b,
  input logic             xc_hold_b,
  input logic             mode_cap_b,
  input logic             cap_b,
  input logic             flag_b,
  input logic             flag_ovf,
  input logic             arm_ovf
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_RSV_BITS: assert property (@(posedge clk) disable iff (rst)
    rd_rsv == 3'b110); // R1

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (dir_up && cnt_cur == TOP && cnt_nxt == '0) |=> flag_ovf); // R3

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (dir_up && cnt_cur == TOP && cnt_nxt == '0 && wr_en && !wr_ovf_bit) |=> flag_ovf); // R9

  AST_NO_BLIND_CLR: assert property (@(posedge clk) disable iff (rst)
    (flag_ovf && !arm_ovf) |=> flag_ovf); // R6

  AST_B_ACK_CLR: assert property (@(posedge clk) disable iff (rst)
    (xc_go_b && !xc_hold_b && mode_cap_b && !cap_b) |=> !flag_b); // R8
endmodule

bind tmr_stat_reg tmr_stat_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_cur    (cnt_cur),
  .cnt_nxt    (cnt_nxt),
  .dir_up     (dir_up),
  .wr_en      (wr_en),
  .wr_ovf_bit (wr_data[3]),
  .rd_rsv     ({rd_data[7:6], rd_data[2]}),
  .xc_go_b    (xc_go_b),
  .xc_hold_b  (xc_hold_b),
  .mode_cap_b (mode_cap_b),
  .cap_b      (cap_b),
  .flag_b     (flag[1]),
  .flag_ovf   (flag[2]),
  .arm_ovf    (arm[2])
);

// File: tb/sim_tmr_stat_reg.sv
module sim_tmr_stat_reg;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] cnt_cur = '0, cnt_nxt = '0, gra = '0, grb = '0;
  logic dir_up = 1'b0;
  logic mode_cap_a = 1'b1, mode_cap_b = 1'b1, cap_a = 1'b0, cap_b = 1'b0;
  logic xc_go_a = 0, xc_hold_a = 0, dm_go_a = 0, dm_clr_en_a = 0;
  logic xc_go_b = 0, xc_hold_b = 0;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic ien_a = 1, ien_b = 1, ien_ovf = 1, ien_unf = 1;
  logic irq_a, irq_b, irq_ovf, irq_unf;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  tmr_stat_reg #(.CNT_W(W)) u0 (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] r);
    rd_en = 1'b1; tick(); rd_en = 1'b0; r = rd_data;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic clear_all();
    logic [7:0] r;
    do_read(r);
    do_write(8'h00);
  endtask

  task automatic set_a();
    mode_cap_a = 1'b1; cap_a = 1'b1; tick(); cap_a = 1'b0;
  endtask

  task automatic set_b();
    mode_cap_b = 1'b1; cap_b = 1'b1; tick(); cap_b = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    // R1 reset state
    do_read(v);
    chk("R1 reset read", v, 8'hC0);

    // R2 R3 R4: every start value in both directions
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 16; c++) begin
        logic [7:0] e;
        clear_all();
        dir_up  = d[0];
        cnt_cur = c[W-1:0];
        cnt_nxt = d[0] ? W'(c + 1) : W'(c - 1);
        tick();
        cnt_cur = cnt_nxt;
        do_read(v);
        e = 8'hC0 | (d[0] ? 8'h20 : 8'h00)
                  | ((d == 1 && c == 15) ? 8'h08 : 8'h00)
                  | ((d == 0 && c == 0)  ? 8'h10 : 8'h00);
        chk("R1 R2 R3 R4 wrap sweep", v, e);
      end
    end

    // R5 compare sweep for A and B
    dir_up = 1'b1;
    for (int s = 0; s < 2; s++) begin
      for (int g = 0; g < 16; g++) begin
        mode_cap_a = (s != 0); mode_cap_b = (s == 0);
        gra = g[W-1:0]; grb = g[W-1:0];
        clear_all();
        cnt_cur = W'(g - 1); cnt_nxt = g[W-1:0];
        tick();
        cnt_cur = g[W-1:0];
        chk("R5 compare hit", s == 0 ? irq_a : irq_b, 1);
        clear_all();
        chk("R5 standing on match", s == 0 ? irq_a : irq_b, 0);
        cnt_nxt = W'(g + 1);
        tick();
        cnt_cur = cnt_nxt;
        chk("R5 stepping past", s == 0 ? irq_a : irq_b, 0);
      end
    end
    mode_cap_a = 1'b1; mode_cap_b = 1'b1;
    clear_all();

    // R5 capture mode ignores matches, compare mode ignores strobes
    gra = 4'd5; cnt_cur = 4'd4; cnt_nxt = 4'd5;
    tick(); cnt_cur = 4'd5;
    chk("R5 capture ignores match", irq_a, 0);
    cap_a = 1'b1; tick(); cap_a = 1'b0;
    chk("R5 capture strobe", irq_a, 1);
    clear_all();
    mode_cap_a = 1'b0; gra = 4'd9;
    cap_a = 1'b1; tick(); cap_a = 1'b0;
    chk("R5 compare ignores strobe", irq_a, 0);
    mode_cap_a = 1'b1;

    // R6 handshake
    set_a();
    do_write(8'h00);
    chk("R6 write without read", irq_a, 1);
    do_read(v);
    chk("R6 read shows A", v[0], 1);
    do_write(8'h01);
    chk("R6 write one", irq_a, 1);
    do_write(8'h00);
    chk("R6 permission used up", irq_a, 1);
    do_read(v);
    do_write(8'h00);
    chk("R6 proper clear", irq_a, 0);
    do_read(v);
    set_a();
    do_write(8'h00);
    chk("R6 read of zero arms nothing", irq_a, 1);
    clear_all();
    set_a(); set_b();
    do_read(v);
    do_write(8'hFE);
    chk("R6 selective clear A", irq_a, 0);
    chk("R6 selective keep B", irq_b, 1);
    do_write(8'hFD);
    chk("R6 B not armed after write", irq_b, 1);
    clear_all();

    // R7 acknowledges on A
    set_a();
    xc_go_a = 1; xc_hold_a = 1; tick();
    chk("R7 hold blocks clear", irq_a, 1);
    xc_hold_a = 0; tick(); xc_go_a = 0;
    chk("R7 controller clears A", irq_a, 0);
    set_a();
    dm_go_a = 1; dm_clr_en_a = 0; tick();
    chk("R7 dma without enable", irq_a, 1);
    dm_clr_en_a = 1; tick(); dm_go_a = 0; dm_clr_en_a = 0;
    chk("R7 dma clears A", irq_a, 0);

    // R8 acknowledges on B
    set_b();
    dm_go_a = 1; dm_clr_en_a = 1; xc_go_a = 1; tick();
    dm_go_a = 0; dm_clr_en_a = 0; xc_go_a = 0;
    chk("R8 A acks leave B", irq_b, 1);
    xc_go_b = 1; xc_hold_b = 1; tick();
    chk("R8 hold blocks clear", irq_b, 1);
    xc_hold_b = 0; tick(); xc_go_b = 0;
    chk("R8 controller clears B", irq_b, 0);

    // R9 set beats clear
    dir_up = 1; cnt_cur = 4'd15; cnt_nxt = 4'd0; tick();
    cnt_cur = 4'd0;
    do_read(v);
    cnt_cur = 4'd15; cnt_nxt = 4'd0;
    do_write(8'h00);
    cnt_cur = 4'd0;
    chk("R9 wrap beats write clear", irq_ovf, 1);
    set_a();
    cap_a = 1; xc_go_a = 1; tick(); cap_a = 0; xc_go_a = 0;
    chk("R9 capture beats ack clear", irq_a, 1);
    clear_all();

    // R10 enable gating
    set_a();
    ien_a = 0; #1;
    chk("R10 masked", irq_a, 0);
    ien_a = 1; #1;
    chk("R10 unmasked", irq_a, 1);
    clear_all();

    // R11 read-only and spare bits
    dir_up = 0;
    do_write(8'hFF);
    do_read(v);
    chk("R11 ones written", v, 8'hC0);
    dir_up = 1;
    do_write(8'h00);
    do_read(v);
    chk("R11 zeros written", v, 8'hE0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule